// File: doc/BRIEF.md
# Serial Port Byte Queue and Watermark Interrupt Front End

This block stands between a 32-bit register bus and a serial shift engine. It holds two byte queues: one the bus fills and the engine drains, and one the engine fills and the bus drains. The bus reaches each queue through a single data register. Bit 31 of that register reports queue status, so software polls and moves data with the same access.

Two programmable thresholds compare against the queue fill levels and give two level-sensitive watermark pending bits. An enable mask selects which of these bits drive the single interrupt output. Software uses the transmit watermark to learn that the engine has drained the queue. It uses the receive watermark to learn that enough bytes have arrived to read back in one burst.

Bus reads are registered. Read data appears on `bus_rdata` in the cycle after a read starts and holds until the next read starts. A read starts on the first cycle in which `bus_rd` is high after a cycle in which it was low.

Top module: `spi_fifo_frontend`

## Requirements
- R1: Byte offsets decode as follows: transmit data 0x48, receive data 0x4C, transmit threshold 0x50, receive threshold 0x54, interrupt enable 0x70, interrupt pending 0x74. Any other offset reads as zero, and a write to it changes nothing.
- R2: A write to offset 0x48 queues bits [7:0] for the engine. The engine sees the queued bytes on `tx_data` in write order while `tx_valid` is high, and consumes one byte per cycle with `tx_take` high. A read of 0x48 returns bit 31 = 1 when the queue is full and bit 31 = 0 otherwise; all other bits read as zero.
- R3: A read of 0x4C returns the oldest received byte in bits [7:0] with bit 31 = 0, and removes that byte. When the queue is empty the read returns 0x8000_0000 and the queue is left unchanged.
- R4: A write to 0x48 while the transmit queue is full is dropped. A byte the engine offers with `rx_valid` while the receive queue is full is dropped.
- R5: Pending bit 0 (transmit watermark) is 1 exactly while the transmit fill level is strictly less than the transmit threshold.
- R6: Pending bit 1 (receive watermark) is 1 exactly while the receive fill level is strictly greater than the receive threshold.
- R7: `irq` is high exactly when a pending bit is 1 and its enable bit is 1. The enable register uses the same bit positions as the pending register: bit 0 transmit, bit 1 receive.
- R8: The pending register is read-only. A write to 0x74 changes neither its read value nor `irq`.
- R9: After reset the transmit threshold reads 1, the receive threshold reads 0, the enable register reads 0, both queues are empty and `irq` is low.
- R10: A read of 0x4C held high for several cycles removes exactly one byte, and `bus_rdata` keeps that byte for the whole hold.
- R11: Each queue holds DEPTH entries (default 8). The transmit queue reports full only after DEPTH bytes have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Engine consumes the oldest transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Enabled watermark interrupt |

## Verification
The bench fills both queues past capacity and checks the bytes that come out. A design that accepted the ninth byte would overwrite the oldest entry or let a stray byte reach the engine. Reads of an empty receive queue are interleaved with real pushes, so a design that moved its read pointer on an empty read would return a stale byte later. One receive read is held for three cycles; a design that popped on every cycle would skip the bytes behind it. The watermark bits are probed at the fill levels on each side of the thresholds, so a design that used less-or-equal where strict comparison is required would flip one count early.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFF_TXDATA = 8'h48;
  localparam logic [BUS_AW-1:0] OFF_RXDATA = 8'h4C;
  localparam logic [BUS_AW-1:0] OFF_TXMARK = 8'h50;
  localparam logic [BUS_AW-1:0] OFF_RXMARK = 8'h54;
  localparam logic [BUS_AW-1:0] OFF_IE     = 8'h70;
  localparam logic [BUS_AW-1:0] OFF_IP     = 8'h74;

  // transmit side asks for data while the level sits under its threshold
  function automatic logic below_mark(int unsigned level, int unsigned mark);
    return level < mark;
  endfunction

  // receive side asks for service once the level exceeds its threshold
  function automatic logic above_mark(int unsigned level, int unsigned mark);
    return level > mark;
  endfunction

  function automatic int unsigned next_slot(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/sff_fifo.sv
module sff_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(sff_pkg::next_slot(32'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(sff_pkg::next_slot(32'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sff_regs.sv
module sff_regs #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [sff_pkg::BUS_AW-1:0] bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      tx_full,
  input  logic [CW-1:0]             tx_level,
  input  logic                      rx_empty,
  input  logic [DW-1:0]             rx_head,
  input  logic [CW-1:0]             rx_level,
  output logic                      tx_push,
  output logic                      rx_pop,
  output logic [CW-1:0]             txmark,
  output logic [CW-1:0]             rxmark,
  output logic [1:0]                ie,
  output logic [1:0]                ip,
  output logic                      irq
);
  import sff_pkg::*;

  logic        rd_q, rd_start;
  logic [31:0] rd_mux;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata[31:DW];
  assign rd_start = bus_rd && !rd_q;
  assign tx_push  = bus_wr && (bus_addr == OFF_TXDATA);
  assign rx_pop   = rd_start && (bus_addr == OFF_RXDATA);

  assign ip[0] = below_mark(32'(tx_level), 32'(txmark));
  assign ip[1] = above_mark(32'(rx_level), 32'(rxmark));
  assign irq   = |(ip & ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txmark <= CW'(1);
      rxmark <= '0;
      ie     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_TXMARK: txmark <= bus_wdata[CW-1:0];
        OFF_RXMARK: rxmark <= bus_wdata[CW-1:0];
        OFF_IE:     ie     <= bus_wdata[1:0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_TXDATA: rd_mux[31] = tx_full;
      OFF_RXDATA: begin
        rd_mux[31] = rx_empty;
        if (!rx_empty) rd_mux[DW-1:0] = rx_head;
      end
      OFF_TXMARK: rd_mux[CW-1:0] = txmark;
      OFF_RXMARK: rd_mux[CW-1:0] = rxmark;
      OFF_IE:     rd_mux[1:0]    = ie;
      OFF_IP:     rd_mux[1:0]    = ip;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rd_q <= bus_rd;
      if (rd_start) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/spi_fifo_frontend.sv
module spi_fifo_frontend #(
  parameter int DEPTH = 8,
  localparam int DW   = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_take,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        irq
);
  logic          tx_push, tx_full, tx_empty;
  logic          rx_pop, rx_full, rx_empty;
  logic [CW-1:0] tx_level, rx_level, txmark, rxmark;
  logic [DW-1:0] rx_head;
  logic [1:0]    ie, ip;

  assign tx_valid = !tx_empty;

  sff_fifo #(.DEPTH(DEPTH), .W(DW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(bus_wdata[DW-1:0]), .pop(tx_take),
    .head(tx_data), .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  sff_fifo #(.DEPTH(DEPTH), .W(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .push_data(rx_data), .pop(rx_pop),
    .head(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  sff_regs #(.DEPTH(DEPTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_full(tx_full), .tx_level(tx_level),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_level(rx_level),
    .tx_push(tx_push), .rx_pop(rx_pop),
    .txmark(txmark), .rxmark(rxmark), .ie(ie), .ip(ip), .irq(irq)
  );

  logic unused_rx_full;
  assign unused_rx_full = rx_full;
endmodule

// File: rtl/sff_checker.sv
module sff_checker #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          tx_take,
  input logic          rx_valid,
  input logic          irq,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] txmark,
  input logic [CW-1:0] rxmark,
  input logic [1:0]    ie
);
  import sff_pkg::*;

  // R4: full transmit queue ignores a bus write
  a_r4_tx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFF_TXDATA && tx_level == CW'(DEPTH) && !tx_take
    |=> tx_level == CW'(DEPTH));

  // R4: full receive queue ignores an engine byte
  a_r4_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_level == CW'(DEPTH) && !bus_rd |=> rx_level == CW'(DEPTH));

  // R10: continuing a read does not pop again
  a_r10_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && $past(bus_rd) && bus_addr == OFF_RXDATA && $past(bus_addr) == OFF_RXDATA
    && !rx_valid |=> rx_level == $past(rx_level));

  // R3: empty read leaves the queue empty
  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == OFF_RXDATA && rx_level == '0 && !rx_valid |=> rx_level == '0);

  // R7: irq only with an enabled watermark condition
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie[0] && tx_level < txmark) || (ie[1] && rx_level > rxmark));

  // R11: levels stay within the depth
  a_r11_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH) && rx_level <= CW'(DEPTH));
endmodule

bind spi_fifo_frontend sff_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .tx_take(tx_take), .rx_valid(rx_valid), .irq(irq),
  .tx_level(tx_level), .rx_level(rx_level), .txmark(txmark), .rxmark(rxmark), .ie(ie)
);

// File: tb/spi_fifo_frontend_test.sv
module spi_fifo_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid, tx_take = 1'b0, rx_valid = 1'b0, irq;
  logic [7:0]  tx_data, rx_data = '0;

  int checks = 0, errors = 0;
  logic [7:0] tx_exp[$];
  logic [7:0] rx_exp[$];
  logic [31:0] rv;

  spi_fifo_frontend #(.DEPTH(DEPTH)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    @(negedge clk);
  endtask

  // driver: transmit byte through the bus, expectation into the scoreboard
  task automatic send_tx(logic [7:0] b);
    bus_write(8'h48, {24'h0, b});
    if (tx_exp.size() < DEPTH) tx_exp.push_back(b);
  endtask

  // driver: engine delivers a received byte
  task automatic push_rx(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (rx_exp.size() < DEPTH) rx_exp.push_back(b);
  endtask

  // monitor: engine drains one transmit byte and compares with the scoreboard
  task automatic drain_tx(string tag);
    logic [7:0] e;
    @(negedge clk);
    e = (tx_exp.size() > 0) ? tx_exp.pop_front() : 8'h00;
    check(tag, {31'h0, tx_valid}, 32'h1);
    check(tag, {24'h0, tx_data}, {24'h0, e});
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  // monitor: bus reads one receive entry, compared with the scoreboard
  task automatic read_rx(string tag);
    logic [31:0] e;
    e = (rx_exp.size() > 0) ? {24'h0, rx_exp.pop_front()} : 32'h8000_0000;
    bus_read(8'h4C, rv);
    check(tag, rv, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check("R9 irq", {31'h0, irq}, 32'h0);
    check("R9 tx_valid", {31'h0, tx_valid}, 32'h0);
    bus_read(8'h50, rv); check("R9 txmark", rv, 32'h1);
    bus_read(8'h54, rv); check("R9 rxmark", rv, 32'h0);
    bus_read(8'h70, rv); check("R9 ie", rv, 32'h0);
    bus_read(8'h74, rv); check("R5 ip at reset", rv, 32'h1);

    // R1 unmapped offset
    bus_write(8'h44, 32'hFFFF_FFFF);
    bus_read(8'h44, rv); check("R1 unmapped", rv, 32'h0);

    // R3 empty read leaves the queue intact
    read_rx("R3 empty");
    push_rx(8'hA5);
    read_rx("R3 data");
    read_rx("R3 empty again");

    // R2 / R11 / R4 transmit fill
    for (int i = 0; i < DEPTH - 1; i++) send_tx(8'(i * 17 + 3));
    bus_read(8'h48, rv); check("R11 not full at DEPTH-1", rv, 32'h0);
    send_tx(8'hC3);
    bus_read(8'h48, rv); check("R2 full flag", rv, 32'h8000_0000);
    send_tx(8'hEE);
    for (int i = 0; i < DEPTH; i++) drain_tx("R2 R4 tx order");
    @(negedge clk); check("R4 tx drained", {31'h0, tx_valid}, 32'h0);

    // R5 transmit watermark
    bus_write(8'h50, 32'd3);
    send_tx(8'h11); send_tx(8'h22);
    bus_read(8'h74, rv); check("R5 level 2 < 3", rv & 32'h1, 32'h1);
    send_tx(8'h33);
    bus_read(8'h74, rv); check("R5 level 3 not < 3", rv & 32'h1, 32'h0);
    for (int i = 0; i < 3; i++) drain_tx("R5 tx drain");

    // R6 receive watermark
    bus_write(8'h54, 32'd2);
    push_rx(8'h51); push_rx(8'h52);
    bus_read(8'h74, rv); check("R6 level 2 not > 2", rv, 32'h1);
    push_rx(8'h53);
    bus_read(8'h74, rv); check("R6 level 3 > 2", rv, 32'h3);

    // R7 interrupt masking
    bus_write(8'h50, 32'd0);
    bus_write(8'h70, 32'h1);
    @(negedge clk); check("R7 tx masked-in but idle", {31'h0, irq}, 32'h0);
    bus_write(8'h70, 32'h2);
    @(negedge clk); check("R7 rx enabled", {31'h0, irq}, 32'h1);
    bus_write(8'h70, 32'h0);
    @(negedge clk); check("R7 disabled", {31'h0, irq}, 32'h0);

    // R8 pending is read-only
    bus_write(8'h74, 32'h0);
    bus_read(8'h74, rv); check("R8 ip unchanged", rv, 32'h2);
    bus_write(8'h70, 32'h2);
    bus_write(8'h74, 32'h0);
    @(negedge clk); check("R8 irq unchanged", {31'h0, irq}, 32'h1);
    bus_write(8'h70, 32'h0);

    // R10 held read pops once
    @(negedge clk);
    bus_addr = 8'h4C; bus_rd = 1'b1;
    @(negedge clk); check("R10 first cycle", bus_rdata, {24'h0, rx_exp.pop_front()});
    rv = bus_rdata;
    @(negedge clk);
    @(negedge clk); check("R10 held data", bus_rdata, rv);
    bus_rd = 1'b0;
    @(negedge clk);
    read_rx("R10 next byte");
    read_rx("R10 last byte");
    read_rx("R10 now empty");

    // R4 receive overflow
    for (int i = 0; i < DEPTH + 1; i++) push_rx(8'(8'h80 + i));
    for (int i = 0; i < DEPTH; i++) read_rx("R4 rx order");
    read_rx("R4 rx dropped");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule